// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a host-side sequencer for a byte-wide multiplexed flash bus. Command bytes, address bytes and data all share one 8-bit bus. A qualifier line tells an address apart from a command or a data byte. Commands and addresses are clocked into the flash by a write strobe. Data bytes move on a separate serial strobe.

A request is accepted on a valid/ready port. It carries an operation code, a 14-bit sector number, an optional 12-bit column and a byte count. The block then produces the whole bus sequence, one clock-accurate phase at a time. For programs it pulls write bytes from a stream port. For reads it returns bytes on a one-cycle valid output. For programs and erases it polls the status register with the output-enable strobe until the ready bit is set. At the end it reports a completion code.

The operation codes are:
- 0: read. Command 00H, then `req_len` bytes.
- 1: spare read. Command F0H, then 64 bytes.
- 2: additive program. Command 10H.
- 3: rewrite program. Command 11H.
- 4: full-sector program. Command 1FH, then 2112 bytes.
- 5: spare program. Command 0FH, then 64 bytes.
- 6: sector erase.

Top module: `flash_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the bus is quiet. `req_ready` is 1. `fl_ce_n`, `fl_we_n`, `fl_sc_n` and `fl_oe_n` are all 1. `fl_dout_en` is 0. `done_valid` is 0.
- R2: Strobes follow these timing rules:
  - At most one of the write, serial and output-enable strobes is low at a time.
  - Each strobe stays low for at least STROBE_LOW (default 2, at least 2) clocks.
  - `fl_ce_n` is low while any strobe is low.
  - `fl_dout` and `fl_cde` are unchanged in the first clock after a strobe rises.
- R3: Every command byte is written on a `fl_we_n` pulse with `fl_cde` = 0. Every address byte is written on a `fl_we_n` pulse with `fl_cde` = 1.
- R4: The sector number is sent as two address bytes. The first is sector bits 7:0. The second is {2'b00, sector bits 13:8}.
- R5: Column address bytes depend on `req_col_en` and the operation:
  - For operations 0, 2 and 3 with `req_col_en` = 1, two column bytes follow the sector bytes. The first is column bits 7:0. The second is {4'h0, column bits 11:8}.
  - For every other operation, the column is ignored and no column bytes are sent.
- R6: A read (op 0) or spare read (op 1) sends its command and addresses. It then issues one `fl_sc_n` pulse per byte, with the bus not driven. Each byte sampled from `fl_din` is returned on `rd_data` with a one-cycle `rd_valid`.
- R7: A program (ops 2 to 5) sends its command, the addresses and the data bytes, then the start command 40H. The data byte count is `req_len` for ops 2 and 3, 2112 for op 4 and 64 for op 5.
- R8: Each program byte is taken from `wr_data` when `wr_valid` and `wr_ready` are both high. It is driven during its `fl_sc_n` pulse. No serial pulse starts while the next byte is unavailable.
- R9: An erase (op 6) sends 20H, then B0H, then the two sector bytes, then polls status.
- R10: Once 40H has been written, no `fl_we_n` pulse occurs until the operation completes. Status is polled with `fl_oe_n` pulses, separated by POLL_GAP idle clocks, until bit 7 of `fl_din` reads 1.
- R11: At completion `done_valid` pulses for one cycle, and the block is idle in that same cycle. `done_code` is {status bit 5, status bit 4} from the final poll for programs and erases, so bit 0 is program fail and bit 1 is erase fail. For reads `done_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 3 | Operation code (0 to 6) |
| req_sector | input | 14 | Sector number |
| req_col_en | input | 1 | Send column address |
| req_col | input | 12 | Column address |
| req_len | input | 12 | Byte count for ops 0, 2, 3 |
| wr_valid | input | 1 | Program byte available |
| wr_data | input | 8 | Program byte |
| wr_ready | output | 1 | Program byte taken when valid |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Read byte |
| done_valid | output | 1 | Operation complete (one cycle) |
| done_code | output | 2 | {erase fail, program fail} |
| fl_ce_n | output | 1 | Flash chip enable |
| fl_we_n | output | 1 | Command/address strobe |
| fl_sc_n | output | 1 | Serial data strobe |
| fl_oe_n | output | 1 | Output enable (status read) |
| fl_cde | output | 1 | 1 = address byte, 0 = command/data |
| fl_dout | output | 8 | Bus value driven to flash |
| fl_dout_en | output | 1 | Bus drive enable |
| fl_din | input | 8 | Bus value from flash |

## Verification
The assertions make three assumptions about the inputs:
- `req_op` lies between 0 and 6.
- `req_len` lies between 1 and 2112 for ops 0, 2 and 3.
- The flash returns a status with bit 7 set within a bounded number of polls.

Under those assumptions, the busy rule holds: nothing strobes `fl_we_n` between the 40H start and `done_valid`.

The stimulus stays within these limits in three ways:
- Every vector uses a legal operation and a length from 1 to 2112.
- The bench's flash model reports busy for a fixed number of polls before it reports ready.
- The write stream is only throttled, never cut off.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int STROBE_LOW   = 2,
  parameter int HOLD         = 1,
  parameter int POLL_GAP     = 4,
  parameter int SECTOR_BYTES = 2112,
  parameter int SPARE_BYTES  = 64,
  localparam int LW = $clog2(SECTOR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [13:0]   req_sector,
  input  logic          req_col_en,
  input  logic [11:0]   req_col,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          done_valid,
  output logic [1:0]    done_code,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_sc_n,
  output logic          fl_oe_n,
  output logic          fl_cde,
  output logic [7:0]    fl_dout,
  output logic          fl_dout_en,
  input  logic [7:0]    fl_din
);
  localparam int SLOT = 1 + STROBE_LOW + HOLD;
  localparam int TMAX = (SLOT > POLL_GAP) ? SLOT : POLL_GAP;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_CMD2, S_SA1, S_SA2, S_CA1, S_CA2, S_DATA, S_GO, S_POLL, S_GAP
  } st_t;

  st_t           st, nxt;
  logic [TW-1:0] tmr;
  logic [2:0]    op_q;
  logic [13:0]   sec_q;
  logic [11:0]   col_q;
  logic          col_en_q;
  logic [LW-1:0] len_q, cnt;
  logic [7:0]    wbyte_q, cmd1;
  logic [2:0]    stat_q;

  wire is_read  = (op_q == 3'd0) || (op_q == 3'd1);
  wire is_erase = (op_q == 3'd6);
  wire use_col  = col_en_q && ((op_q == 3'd0) || (op_q == 3'd2) || (op_q == 3'd3));
  wire addr_ph  = (st == S_SA1) || (st == S_SA2) || (st == S_CA1) || (st == S_CA2);
  wire we_ph    = addr_ph || (st == S_CMD1) || (st == S_CMD2) || (st == S_GO);
  wire wdata_ph = (st == S_DATA) && !is_read;
  wire low      = (tmr >= TW'(1)) && (tmr <= TW'(STROBE_LOW));
  wire stall    = wdata_ph && (tmr == '0) && !wr_valid;
  wire end_beat = (tmr == TW'(SLOT - 1));
  wire smp      = (tmr == TW'(STROBE_LOW));
  wire last     = (cnt == len_q - 1'b1);

  assign req_ready  = (st == S_IDLE);
  assign fl_ce_n    = (st == S_IDLE);
  assign fl_we_n    = !(we_ph && low);
  assign fl_sc_n    = !((st == S_DATA) && low);
  assign fl_oe_n    = !((st == S_POLL) && low);
  assign fl_cde     = addr_ph;
  assign fl_dout_en = we_ph || wdata_ph;
  assign wr_ready   = wdata_ph && (tmr == '0);

  always_comb begin
    case (op_q)
      3'd0:    cmd1 = 8'h00;
      3'd1:    cmd1 = 8'hF0;
      3'd2:    cmd1 = 8'h10;
      3'd3:    cmd1 = 8'h11;
      3'd4:    cmd1 = 8'h1F;
      3'd5:    cmd1 = 8'h0F;
      default: cmd1 = 8'h20;
    endcase
  end

  always_comb begin
    case (st)
      S_CMD1:  fl_dout = cmd1;
      S_CMD2:  fl_dout = 8'hB0;
      S_SA1:   fl_dout = sec_q[7:0];
      S_SA2:   fl_dout = {2'b00, sec_q[13:8]};
      S_CA1:   fl_dout = col_q[7:0];
      S_CA2:   fl_dout = {4'h0, col_q[11:8]};
      S_DATA:  fl_dout = is_read ? 8'h00 : wbyte_q;
      S_GO:    fl_dout = 8'h40;
      default: fl_dout = 8'h00;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_CMD1: nxt = is_erase ? S_CMD2 : S_SA1;
      S_CMD2: nxt = S_SA1;
      S_SA1:  nxt = S_SA2;
      S_SA2:  nxt = is_erase ? S_POLL : (use_col ? S_CA1 : S_DATA);
      S_CA1:  nxt = S_CA2;
      S_CA2:  nxt = S_DATA;
      S_DATA: nxt = last ? (is_read ? S_IDLE : S_GO) : S_DATA;
      S_GO:   nxt = S_POLL;
      S_POLL: nxt = stat_q[2] ? S_IDLE : S_GAP;
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; op_q <= '0; sec_q <= '0; col_q <= '0; col_en_q <= 1'b0;
      len_q <= '0; cnt <= '0; wbyte_q <= '0; stat_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done_valid <= 1'b0; done_code <= '0;
    end else begin
      rd_valid   <= 1'b0;
      done_valid <= 1'b0;
      if (wr_valid && wr_ready) wbyte_q <= wr_data;
      if (smp && (st == S_DATA) && is_read) begin
        rd_valid <= 1'b1;
        rd_data  <= fl_din;
      end
      if (smp && (st == S_POLL)) stat_q <= {fl_din[7], fl_din[5], fl_din[4]};
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; sec_q <= req_sector; col_q <= req_col; col_en_q <= req_col_en;
          cnt <= '0; tmr <= '0; st <= S_CMD1;
          case (req_op)
            3'd1, 3'd5: len_q <= LW'(SPARE_BYTES);
            3'd4:       len_q <= LW'(SECTOR_BYTES);
            default:    len_q <= req_len;
          endcase
        end
        S_GAP: begin
          if (tmr == TW'(POLL_GAP - 1)) begin
            tmr <= '0;
            st  <= S_POLL;
          end else tmr <= tmr + 1'b1;
        end
        default: if (!stall) begin
          if (end_beat) begin
            tmr <= '0;
            st  <= nxt;
            if (st == S_DATA) cnt <= cnt + 1'b1;
            if (nxt == S_IDLE) begin
              done_valid <= 1'b1;
              done_code  <= is_read ? 2'b00 : stat_q[1:0];
            end
          end else tmr <= tmr + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fl_ce_n,
  input logic       fl_we_n,
  input logic       fl_sc_n,
  input logic       fl_oe_n,
  input logic       fl_cde,
  input logic [7:0] fl_dout,
  input logic       fl_dout_en,
  input logic       done_valid,
  input logic       req_ready
);
  logic busy_q, we_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_prev <= 1'b1;
    end else begin
      we_prev <= fl_we_n;
      if (done_valid) busy_q <= 1'b0;
      else if (!we_prev && fl_we_n && !fl_cde && fl_dout == 8'h40) busy_q <= 1'b1;
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!fl_we_n, !fl_sc_n, !fl_oe_n}));
  a_r2_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_sc_n || !fl_oe_n) |-> !fl_ce_n);
  a_r2_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |=> !fl_we_n);
  a_r2_sc_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_sc_n) |=> !fl_sc_n);
  a_r2_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_dout) && $stable(fl_cde)));
  a_r2_sc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_sc_n) && fl_dout_en) |-> $stable(fl_dout));
  a_r10_no_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> fl_we_n);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (req_ready && fl_ce_n));
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_sc_n(fl_sc_n),
  .fl_oe_n(fl_oe_n), .fl_cde(fl_cde), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
  .done_valid(done_valid), .req_ready(req_ready)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [13:0] sec;
    logic        cen;
    logic [11:0] col;
    logic [11:0] len;
    logic [3:0]  busy;
    logic [1:0]  sfail;
    logic        stall;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [0:NV-1] = '{
    '{3'd0, 14'h2A5C, 1'b0, 12'h000, 12'd5, 4'd0, 2'b00, 1'b0},
    '{3'd0, 14'h3FFF, 1'b1, 12'h83A, 12'd4, 4'd0, 2'b00, 1'b0},
    '{3'd1, 14'h0001, 1'b1, 12'h123, 12'd0, 4'd0, 2'b00, 1'b0},
    '{3'd2, 14'h1234, 1'b1, 12'h105, 12'd6, 4'd3, 2'b00, 1'b1},
    '{3'd3, 14'h0000, 1'b0, 12'h000, 12'd3, 4'd1, 2'b01, 1'b0},
    '{3'd5, 14'h0F0F, 1'b1, 12'h7FF, 12'd0, 4'd2, 2'b00, 1'b0},
    '{3'd6, 14'h2001, 1'b0, 12'h000, 12'd0, 4'd4, 2'b10, 1'b0},
    '{3'd4, 14'h0005, 1'b1, 12'h0AA, 12'd0, 4'd0, 2'b00, 1'b1},
    '{3'd0, 14'h0100, 1'b1, 12'h000, 12'd1, 4'd0, 2'b00, 1'b0},
    '{3'd2, 14'h3000, 1'b0, 12'h000, 12'd1, 4'd0, 2'b11, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_col_en = 1'b0;
  logic [2:0] req_op = '0;
  logic [13:0] req_sector = '0;
  logic [11:0] req_col = '0, req_len = '0;
  logic wr_valid, wr_ready, rd_valid, done_valid;
  logic [7:0] wr_data, rd_data, fl_dout, fl_din;
  logic [1:0] done_code;
  logic req_ready, fl_ce_n, fl_we_n, fl_sc_n, fl_oe_n, fl_cde, fl_dout_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sector(req_sector), .req_col_en(req_col_en), .req_col(req_col), .req_len(req_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .done_valid(done_valid), .done_code(done_code), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_sc_n(fl_sc_n), .fl_oe_n(fl_oe_n), .fl_cde(fl_cde),
    .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din)
  );

  int n_cmp = 0, n_bad = 0;
  logic [13:0] cur_sec = '0;
  logic [1:0]  sfail_m = '0;
  int busy_ld = 0, busy = 0, polls = 0, idx = 0, acnt = 0;
  int wn = 0, dn = 0, dbad = 0, sc_early = 0, rcnt = 0, rbad = 0, rstart = 0;
  logic [7:0] ca_lo = '0;
  logic [7:0] wlog_b [0:15];
  logic       wlog_c [0:15];
  logic pwe = 1'b1, psc = 1'b1, poe = 1'b1;
  logic wr_on = 1'b0, stall_en = 1'b0, tog = 1'b0;
  int wcnt = 0;

  function automatic logic [7:0] fdat(input int i);
    return 8'(i * 7 + 3) ^ cur_sec[7:0];
  endfunction
  function automatic logic [7:0] gdat(input int k);
    return 8'(k * 5 + 9);
  endfunction

  assign wr_data  = gdat(wcnt);
  assign wr_valid = wr_on && (!stall_en || tog);
  assign fl_din   = !fl_oe_n ? ((busy > 0) ? 8'h00 : {2'b10, sfail_m, 4'h0}) : fdat(idx);

  always @(posedge clk) if (wr_valid && wr_ready) wcnt <= wcnt + 1;

  always @(negedge clk) begin
    tog = ~tog;
    if (!pwe && fl_we_n) begin
      if (wn < 16) begin wlog_b[wn] = fl_dout; wlog_c[wn] = fl_cde; end
      wn++;
      if (!fl_cde) begin
        acnt = 0;
        if (fl_dout == 8'h00) idx = 0;
        if (fl_dout == 8'hF0) idx = 2048;
        if (fl_dout == 8'h40 || fl_dout == 8'hB0) busy = busy_ld;
      end else begin
        acnt++;
        if (acnt == 3) ca_lo = fl_dout;
        if (acnt == 4) idx = {20'd0, fl_dout[3:0], ca_lo};
      end
    end
    if (psc && !fl_sc_n && wr_on && wcnt <= dn) sc_early++;
    if (!psc && fl_sc_n) begin
      if (fl_dout_en) begin
        if (fl_dout != gdat(dn)) dbad++;
        dn++;
      end else idx++;
    end
    if (!poe && fl_oe_n) begin
      polls++;
      if (busy > 0) busy--;
    end
    if (rd_valid) begin
      if (rd_data != fdat(rstart + rcnt)) rbad++;
      rcnt++;
    end
    pwe = fl_we_n; psc = fl_sc_n; poe = fl_oe_n;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0] eb [0:15];
    logic       ec [0:15];
    int en, elen, t, seq_ok;
    logic prog, colx;
    prog = (v.op >= 3'd2) && (v.op <= 3'd5);
    colx = v.cen && (v.op == 3'd0 || v.op == 3'd2 || v.op == 3'd3);
    elen = (v.op == 3'd1 || v.op == 3'd5) ? 64 : (v.op == 3'd4) ? 2112 : int'(v.len);
    en = 0;
    case (v.op)
      3'd0: eb[0] = 8'h00; 3'd1: eb[0] = 8'hF0; 3'd2: eb[0] = 8'h10; 3'd3: eb[0] = 8'h11;
      3'd4: eb[0] = 8'h1F; 3'd5: eb[0] = 8'h0F; default: eb[0] = 8'h20;
    endcase
    ec[0] = 1'b0; en = 1;
    if (v.op == 3'd6) begin eb[en] = 8'hB0; ec[en] = 1'b0; en++; end
    eb[en] = v.sec[7:0]; ec[en] = 1'b1; en++;
    eb[en] = {2'b00, v.sec[13:8]}; ec[en] = 1'b1; en++;
    if (colx) begin
      eb[en] = v.col[7:0]; ec[en] = 1'b1; en++;
      eb[en] = {4'h0, v.col[11:8]}; ec[en] = 1'b1; en++;
    end
    if (prog) begin eb[en] = 8'h40; ec[en] = 1'b0; en++; end
    rstart = colx ? int'(v.col) : (v.op == 3'd1 ? 2048 : 0);

    @(negedge clk);
    cur_sec = v.sec; sfail_m = v.sfail; busy_ld = int'(v.busy); busy = 0;
    wn = 0; dn = 0; dbad = 0; sc_early = 0; polls = 0; rcnt = 0; rbad = 0;
    wcnt = 0; stall_en = v.stall; wr_on = prog;
    req_op = v.op; req_sector = v.sec; req_col_en = v.cen; req_col = v.col; req_len = v.len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (t < 30000) begin
      if (done_valid) break;
      @(negedge clk);
      t++;
    end
    chk(t < 30000, "R11 completion seen", t, 30000);
    seq_ok = (wn == en);
    for (int i = 0; i < en && i < 16; i++)
      if (wlog_b[i] != eb[i] || wlog_c[i] != ec[i]) seq_ok = 0;
    // R3 R4 R5 R7 R9: command/address byte sequence and qualifier
    chk(seq_ok != 0, "R3 R4 R5 R7 R9 command/address sequence", wn, en);
    chk(done_code == (prog || v.op == 3'd6 ? v.sfail : 2'b00), "R11 done code",
        int'(done_code), int'(prog || v.op == 3'd6 ? v.sfail : 2'b00));
    if (v.op <= 3'd1) begin
      chk(rcnt == elen && rbad == 0 && dn == 0, "R6 read bytes", rcnt - rbad, elen);
      chk(polls == 0, "R6 no status poll on read", polls, 0);
    end else begin
      chk(polls == int'(v.busy) + 1, "R10 poll count until ready", polls, int'(v.busy) + 1);
      chk(rcnt == 0, "R10 no read data", rcnt, 0);
    end
    if (prog) begin
      chk(dn == elen && dbad == 0, "R7 program data bytes", dn - dbad, elen);
      chk(sc_early == 0 && wcnt == elen, "R8 serial pulse only with a taken byte", sc_early, 0);
    end else if (v.op == 3'd6) begin
      chk(dn == 0, "R9 erase moves no data", dn, 0);
    end
    wr_on = 1'b0;
  endtask

  task automatic chk_idle(input string tag);
    chk(req_ready && fl_ce_n && fl_we_n && fl_sc_n && fl_oe_n && !fl_dout_en && !done_valid,
        tag, {req_ready, fl_ce_n, fl_we_n, fl_sc_n, fl_oe_n, fl_dout_en, done_valid},
        7'b1111100);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset release");

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: reset in the middle of a program returns the bus to quiet
    @(negedge clk);
    wr_on = 1'b1; stall_en = 1'b0; busy_ld = 5;
    req_op = 3'd2; req_sector = 14'h0777; req_col_en = 1'b0; req_len = 12'd8; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (25) @(negedge clk);
    chk(!fl_ce_n, "R1 busy before mid-operation reset", fl_ce_n, 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 quiet during mid-operation reset");
    @(negedge clk);
    rst_n = 1'b1; wr_on = 1'b0;
    @(negedge clk);
    chk_idle("R1 idle after mid-operation reset");
    run_vec(VEC[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule